// File: doc/BRIEF.md
# Configuration Readback Serial Controller

This block sends stored configuration frames out of the chip one bit per clock on a serial data output. It runs on the configuration clock. An active-low request pin starts a session and must stay low for as long as the session runs. A session reads frames in rising address order through a synchronous read port. The read port takes a frame address and a bit index and returns one data bit on the following clock. Each frame is sent as a two-bit alignment preamble, 0 and then 1, followed by the frame's data bits with bit 0 first. The first frame sent is the one named by a start-address input, which a processor-interface register normally drives. After the last frame the output idles high.

Several conditions gate a session. Readback is only possible after configuration has completed, while the processor interface is disabled, and while a mode bit gives the request pin to readback. A two-bit permission setting allows readback never, once per reset, or without limit. The same request pin can instead drive a global tri-state output. The pin always drives that output before configuration completes, and after configuration it drives it only when the mode bit gives the pin to that function.

A control state machine has six states:
- IDLE: waiting for a start.
- LATENCY: the output idles high for a fixed number of clocks.
- PRE0: the output sends the preamble 0.
- PRE1: the output sends the preamble 1, and the first data bit is fetched.
- DATA: one data bit is sent per clock, and the next bit is fetched.
- DONE: the session has ended and the block waits for the request to be released.

The state machine takes these transitions:
- IDLE→LATENCY on a qualified start.
- LATENCY→PRE0 when the latency count ends.
- PRE0→PRE1.
- PRE1→DATA.
- DATA→PRE0 at the end of a frame that is not the last.
- DATA→DONE at the end of the last frame.
- DONE→IDLE when the request is released or the path closes.
- Any active state→IDLE on an abort.

Top module: `rbk_serial_ctrl`

## Requirements
- R1: A qualified start makes `busy` go high after that clock edge. A start is qualified when all of these hold at a rising edge: `req_n` is sampled low, `req_n` was sampled high at the two edges before it, `cfg_done`=1, `mode_rb`=1, `mpi_en`=0, and the permission allows it. For START_LAT edges after the start (default 3), `sdo` stays high.
- R2: After the latency, exactly one bit is sent per rising edge. Each frame is sent as a 0, then a 1, then FRAME_BITS data bits from bit index 0 upward. The data bits are the values the read port returned.
- R3: Frames are sent from `start_addr` (latched at the start) through frame FRAME_COUNT-1, in rising order. A `start_addr` of FRAME_COUNT or more starts at frame 0.
- R4: After the last data bit of frame FRAME_COUNT-1, `busy` is 0 and `sdo` is 1. They stay that way while `req_n` stays low.
- R5: If `req_n` is sampled high during a session, the session aborts. After that edge `busy` is 0 and `sdo` is 1.
- R6: A restart needs `req_n` to be sampled high at two or more consecutive edges before it goes low. A single high sample followed by low does not start a session. This also applies to the first session after reset.
- R7: Permission `perm`=2'b00 blocks every session.
- R8: Permission `perm`=2'b01 allows a session only if no session has started since reset. A sticky flag is set at every session start and is cleared only by reset.
- R9: Permission `perm`=2'b10 or 2'b11 allows any number of sessions.
- R10: When `mpi_en`=1, no session starts and `sdo` stays 1. If `mpi_en` rises during a session, the session aborts after that edge.
- R11: While `cfg_done`=0, `gts` equals the inverse of `req_n` and no session starts. After configuration, `mode_rb`=0 makes `gts` equal the inverse of `req_n` and blocks readback. After configuration, `mode_rb`=1 holds `gts` at 0.
- R12: After reset, `sdo`=1 and `busy`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_n | input | 1 | Active-low request pin, shared with global tri-state |
| cfg_done | input | 1 | Configuration completed |
| mode_rb | input | 1 | 1: pin drives readback after configuration; 0: pin drives global tri-state |
| mpi_en | input | 1 | Processor interface enabled; blocks pin-driven readback |
| perm | input | 2 | Permission: 00 never, 01 once, 1x unlimited |
| start_addr | input | ADDR_W | First frame address of a session |
| mem_frame | output | ADDR_W | Read port frame address |
| mem_bit | output | BIT_W | Read port bit index |
| mem_data | input | 1 | Read port data, registered one clock after address |
| sdo | output | 1 | Serial readback data, idles high |
| busy | output | 1 | Session in progress |
| gts | output | 1 | Global tri-state request |

## Verification
A wrong latency or preamble counter shows up as a wrong `sdo` bit within START_LAT+2 edges of the start. A frame-address or bit-index fault corrupts the data bits of the very frame where it occurs. A fault in the high-sample counter or the one-shot flag shows up as `busy` rising, or failing to rise, one edge after a falling request. A fault in the abort or gating logic leaves `busy` high one edge after `req_n` rises or `mpi_en` rises.

// File: rtl/rbk_pkg.sv
package rbk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LATENCY,
        ST_PRE0,
        ST_PRE1,
        ST_DATA,
        ST_DONE
    } rbk_state_e;

    localparam logic [1:0] PERM_NEVER = 2'b00;
    localparam logic [1:0] PERM_ONCE  = 2'b01;

endpackage

// File: rtl/rbk_req_qual.sv
// Request qualification: consecutive-high counting, permission and path gating,
// and the shared global tri-state routing.
module rbk_req_qual (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_n,
    input  logic       cfg_done,
    input  logic       mode_rb,
    input  logic       mpi_en,
    input  logic [1:0] perm,
    input  logic       take,
    output logic       path_open,
    output logic       start_ok,
    output logic       gts
);
    import rbk_pkg::*;

    logic [1:0] hi_cnt;
    logic       used_q;
    logic       perm_ok;

    // Saturating count of consecutive edges with the request released.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt <= 2'd0;
        end else if (req_n) begin
            hi_cnt <= (hi_cnt == 2'd2) ? 2'd2 : hi_cnt + 2'd1;
        end else begin
            hi_cnt <= 2'd0;
        end
    end

    // Sticky flag: a session has started since reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            used_q <= 1'b0;
        end else if (take) begin
            used_q <= 1'b1;
        end
    end

    always_comb begin
        unique case (perm)
            PERM_NEVER: perm_ok = 1'b0;
            PERM_ONCE:  perm_ok = ~used_q;
            default:    perm_ok = 1'b1;
        endcase
    end

    assign path_open = cfg_done & mode_rb & ~mpi_en;
    assign start_ok  = path_open & ~req_n & (hi_cnt == 2'd2) & perm_ok;
    assign gts       = (~cfg_done | ~mode_rb) & ~req_n;

endmodule

// File: rtl/rbk_frame_seq.sv
// Latency, bit and frame counters for one session.
module rbk_frame_seq #(
    parameter int FRAME_BITS  = 8,
    parameter int FRAME_COUNT = 5,
    parameter int START_LAT   = 3,
    localparam int ADDR_W = $clog2(FRAME_COUNT + 1),
    localparam int BIT_W  = $clog2(FRAME_BITS),
    localparam int LAT_W  = $clog2(START_LAT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              lat_en,
    input  logic              bit_en,
    output logic              lat_last,
    output logic              bit_last,
    output logic              frame_last,
    output logic [ADDR_W-1:0] rd_frame,
    output logic [BIT_W-1:0]  bit_cnt
);
    logic [LAT_W-1:0] lat_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_cnt <= '0;
        end else if (load) begin
            lat_cnt <= '0;
        end else if (lat_en) begin
            lat_cnt <= lat_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
        end else if (load) begin
            bit_cnt <= '0;
        end else if (bit_en) begin
            bit_cnt <= bit_last ? '0 : bit_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_frame <= '0;
        end else if (load) begin
            rd_frame <= (start_addr < ADDR_W'(FRAME_COUNT)) ? start_addr : '0;
        end else if (bit_en && bit_last) begin
            rd_frame <= rd_frame + 1'b1;
        end
    end

    assign lat_last   = (lat_cnt == LAT_W'(START_LAT - 1));
    assign bit_last   = (bit_cnt == BIT_W'(FRAME_BITS - 1));
    assign frame_last = (rd_frame == ADDR_W'(FRAME_COUNT - 1));

endmodule

// File: rtl/rbk_serial_ctrl.sv
// Readback session state machine and serial output.
module rbk_serial_ctrl #(
    parameter int FRAME_BITS  = 8,
    parameter int FRAME_COUNT = 5,
    parameter int START_LAT   = 3,
    localparam int ADDR_W = $clog2(FRAME_COUNT + 1),
    localparam int BIT_W  = $clog2(FRAME_BITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_n,
    input  logic              cfg_done,
    input  logic              mode_rb,
    input  logic              mpi_en,
    input  logic [1:0]        perm,
    input  logic [ADDR_W-1:0] start_addr,
    output logic [ADDR_W-1:0] mem_frame,
    output logic [BIT_W-1:0]  mem_bit,
    input  logic              mem_data,
    output logic              sdo,
    output logic              busy,
    output logic              gts
);
    import rbk_pkg::*;

    rbk_state_e        state_q, state_d;
    logic              path_open, start_ok, take, run;
    logic              lat_last, bit_last, frame_last;
    logic [BIT_W-1:0]  bit_cnt;

    assign run  = path_open & ~req_n;
    assign take = (state_q == ST_IDLE) && start_ok;

    rbk_req_qual u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_n     (req_n),
        .cfg_done  (cfg_done),
        .mode_rb   (mode_rb),
        .mpi_en    (mpi_en),
        .perm      (perm),
        .take      (take),
        .path_open (path_open),
        .start_ok  (start_ok),
        .gts       (gts)
    );

    rbk_frame_seq #(
        .FRAME_BITS  (FRAME_BITS),
        .FRAME_COUNT (FRAME_COUNT),
        .START_LAT   (START_LAT)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (take),
        .start_addr (start_addr),
        .lat_en     (state_q == ST_LATENCY),
        .bit_en     (state_q == ST_DATA),
        .lat_last   (lat_last),
        .bit_last   (bit_last),
        .frame_last (frame_last),
        .rd_frame   (mem_frame),
        .bit_cnt    (bit_cnt)
    );

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_ok) state_d = ST_LATENCY;
            ST_LATENCY: begin
                if (!run)          state_d = ST_IDLE;
                else if (lat_last) state_d = ST_PRE0;
            end
            ST_PRE0:    state_d = run ? ST_PRE1 : ST_IDLE;
            ST_PRE1:    state_d = run ? ST_DATA : ST_IDLE;
            ST_DATA: begin
                if (!run)          state_d = ST_IDLE;
                else if (bit_last) state_d = frame_last ? ST_DONE : ST_PRE0;
            end
            ST_DONE:    if (!run) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Outputs: the read port is addressed one bit ahead of the serial output.
    always_comb begin
        sdo     = 1'b1;
        busy    = 1'b0;
        mem_bit = '0;
        unique case (state_q)
            ST_LATENCY: busy = 1'b1;
            ST_PRE0: begin
                busy = 1'b1;
                sdo  = 1'b0;
            end
            ST_PRE1:    busy = 1'b1;
            ST_DATA: begin
                busy    = 1'b1;
                sdo     = mem_data;
                mem_bit = bit_last ? '0 : bit_cnt + 1'b1;
            end
            default: begin
                sdo  = 1'b1;
                busy = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/rbk_serial_ctrl_chk.sv
// Port-level properties of the readback controller.
module rbk_serial_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_n,
    input logic       cfg_done,
    input logic       mode_rb,
    input logic       mpi_en,
    input logic [1:0] perm,
    input logic       sdo,
    input logic       busy,
    input logic       gts
);

    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sdo); // R4

    AST_ABORT_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_n) |=> !busy); // R5

    AST_PATH_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_done || !mode_rb || mpi_en) |=> !busy); // R10

    AST_TWO_HIGH_BEFORE_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(req_n, 2) && $past(req_n, 3))); // R6

    AST_NEVER_PERMITTED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(perm) != 2'b00)); // R7

    AST_GTS_QUIET_IN_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_done && mode_rb) |-> !gts); // R11

    AST_START_PREAMBLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> sdo); // R1

endmodule

bind rbk_serial_ctrl rbk_serial_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_n    (req_n),
    .cfg_done (cfg_done),
    .mode_rb  (mode_rb),
    .mpi_en   (mpi_en),
    .perm     (perm),
    .sdo      (sdo),
    .busy     (busy),
    .gts      (gts)
);

// File: tb/rbk_serial_ctrl_test.sv
module rbk_serial_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int FB   = 8;
    localparam int FC   = 5;
    localparam int LAT  = 3;
    localparam int AW   = $clog2(FC + 1);
    localparam int BW   = $clog2(FB);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_n = 1'b1;
    logic          cfg_done = 1'b0;
    logic          mode_rb = 1'b1;
    logic          mpi_en = 1'b0;
    logic [1:0]    perm = 2'b10;
    logic [AW-1:0] start_addr = '0;
    logic [AW-1:0] mem_frame;
    logic [BW-1:0] mem_bit;
    logic          rd_q;
    logic          sdo, busy, gts;
    logic [FB-1:0] mem [FC];

    int n_vec = 0;
    int n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rbk_serial_ctrl #(.FRAME_BITS(FB), .FRAME_COUNT(FC), .START_LAT(LAT)) uut (
        .clk(clk), .rst_n(rst_n), .req_n(req_n), .cfg_done(cfg_done),
        .mode_rb(mode_rb), .mpi_en(mpi_en), .perm(perm), .start_addr(start_addr),
        .mem_frame(mem_frame), .mem_bit(mem_bit), .mem_data(rd_q),
        .sdo(sdo), .busy(busy), .gts(gts)
    );

    // Synchronous frame memory model.
    always_ff @(posedge clk) begin
        if (int'(mem_frame) < FC) rd_q <= mem[int'(mem_frame)][mem_bit];
        else                      rd_q <= 1'b0;
    end

    task automatic check(input string tag, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    // Expected serial bit after the j-th edge following the start edge.
    function automatic logic exp_bit(input int j, input int eff);
        int k, fr, pos, f;
        if (j < LAT) return 1'b1;
        k   = j - LAT;
        fr  = k / (FB + 2);
        pos = k % (FB + 2);
        f   = eff + fr;
        if (f >= FC) return 1'b1;
        if (pos == 0) return 1'b0;
        if (pos == 1) return 1'b1;
        return mem[f][pos - 2];
    endfunction

    // Runs a session; ab_kind 1 aborts with request release, 2 with mpi_en.
    task automatic run_sess(input int base, input int ab_at, input int ab_kind);
        int eff, total;
        eff   = (base < FC) ? base : 0;
        total = LAT + (FC - eff) * (FB + 2);
        start_addr = AW'(base);
        req_n = 1'b0;
        for (int j = 0; j <= total + 2; j++) begin
            tick();
            start_addr = AW'($urandom_range(0, 7));
            if (j < total) begin
                check("R2/R3 sdo stream", sdo, exp_bit(j, eff));
                check("R1 busy in session", busy, 1'b1);
            end else begin
                check("R4 sdo after end", sdo, 1'b1);
                check("R4 busy after end", busy, 1'b0);
            end
            check("R11 gts quiet in readback", gts, 1'b0);
            if (j == ab_at && ab_kind != 0) begin
                if (ab_kind == 1) req_n = 1'b1;
                else              mpi_en = 1'b1;
                tick();
                check(ab_kind == 1 ? "R5 abort busy" : "R10 abort busy", busy, 1'b0);
                check(ab_kind == 1 ? "R5 abort sdo" : "R10 abort sdo", sdo, 1'b1);
                break;
            end
        end
        req_n  = 1'b1;
        mpi_en = 1'b0;
        idle(2);
    endtask

    task automatic expect_blocked(input string tag, input int n);
        req_n = 1'b0;
        for (int i = 0; i < n; i++) begin
            tick();
            check(tag, busy, 1'b0);
            check(tag, sdo, 1'b1);
        end
        req_n = 1'b1;
        idle(2);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        report();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int f = 0; f < FC; f++) mem[f] = FB'($urandom);
        idle(3);
        rst_n = 1'b1;
        tick();
        check("R12 reset sdo", sdo, 1'b1);
        check("R12 reset busy", busy, 1'b0);
        check("R11 gts released", gts, 1'b0);

        // Before configuration: pin drives gts, no readback.
        req_n = 1'b0;
        for (int i = 0; i < 4; i++) begin
            tick();
            check("R11 gts follows pin pre-config", gts, 1'b1);
            check("R11 no readback pre-config", busy, 1'b0);
        end
        req_n = 1'b1;
        idle(3);

        // After configuration with pin assigned to tri-state.
        cfg_done = 1'b1;
        mode_rb  = 1'b0;
        req_n = 1'b0;
        for (int i = 0; i < 4; i++) begin
            tick();
            check("R11 gts follows pin in tri-state mode", gts, 1'b1);
            check("R11 readback blocked in tri-state mode", busy, 1'b0);
        end
        req_n = 1'b1;
        tick();
        check("R11 gts released", gts, 1'b0);
        idle(2);
        mode_rb = 1'b1;

        // Full sessions, several start addresses (R1 R2 R3 R4 R9).
        run_sess(0, -1, 0);
        run_sess(2, -1, 0);
        run_sess(6, -1, 0);
        run_sess(FC - 1, -1, 0);

        // Abort, then a single high sample must not restart (R5 R6).
        run_sess(1, 9, 1);
        req_n = 1'b0;
        idle(3);
        check("R1 busy up", busy, 1'b1);
        req_n = 1'b1;
        tick();
        check("R5 aborted", busy, 1'b0);
        req_n = 1'b0;
        for (int i = 0; i < 5; i++) begin
            tick();
            check("R6 short high no restart", busy, 1'b0);
            check("R6 short high sdo idle", sdo, 1'b1);
        end
        req_n = 1'b1;
        idle(2);
        run_sess(0, -1, 0);

        // Processor interface enabled (R10).
        mpi_en = 1'b1;
        expect_blocked("R10 mpi blocks start", 6);
        mpi_en = 1'b0;
        run_sess(3, 5, 2);

        // Never permitted (R7).
        perm = 2'b00;
        expect_blocked("R7 prohibit", 6);

        // One-shot after reset (R8).
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        perm = 2'b01;
        idle(2);
        run_sess(0, -1, 0);
        expect_blocked("R8 second session refused", 6);

        // Unlimited with the other encoding (R9).
        perm = 2'b11;
        run_sess(4, -1, 0);
        run_sess(4, -1, 0);

        // Random sessions.
        perm = 2'b10;
        for (int r = 0; r < 16; r++) begin
            int b, k, at;
            b  = $urandom_range(0, 7);
            k  = $urandom_range(0, 2);
            at = $urandom_range(0, LAT + FC * (FB + 2));
            run_sess(b, at, k);
        end

        report();
        $finish;
    end

endmodule